// File: doc/BRIEF.md
# Power-Aware Banked Word Memory

This block is an on-chip word memory split into a parameterised number of equal banks. A single 32-bit request/grant port sits in front of the banks. Each access carries a byte address, a write flag, per-byte enables and write data. Every request is granted in the cycle it is raised. Its response, a valid pulse with read data and an error flag, follows one cycle later. At most one word moves per cycle.

A build-time parameter fixes how word addresses spread over the banks:

- **Contiguous:** each bank owns one consecutive slice, and the high word-address bits name the bank.
- **Interleaved:** successive words rotate across the banks, and the low word-address bits name the bank.

A power-setting register holds one 2-bit field per bank. Each field selects active, retention or off. Retention keeps a bank's contents but blocks access to it. Off drops the contents. Because an interleaved layout spreads every data structure over all banks, that layout keeps every bank active and refuses any lowering. Accesses to a bank that is not active, to a misaligned address, or past the end of the memory are answered with an error.

In a contiguous build, software parks unused banks in retention or off. It rewrites any bank that comes back from off before it trusts that bank's data.

Top module: `pm_bank_mem`

## Requirements
- R1: After reset every bank is active (power state output all zeros) and the response valid output is low.
- R2: The grant output is high in the same cycle as any raised request, so one word can be moved per cycle.
- R3: In contiguous mode the word index (byte address divided by 4) selects bank = index / BANK_WORDS and offset = index mod BANK_WORDS.
- R4: In interleaved mode the word index selects bank = index mod NUM_BANKS and offset = index / NUM_BANKS. Each word is stored at its own location, so every address reads back what was last written there.
- R5: Exactly one cycle after a granted request, the valid output pulses high with the response. For a successful read, the read data is the addressed word. For a write or an error, the read data is zero. With no request, valid stays low.
- R6: Byte enable bit k gates write data bits [8k+7:8k]. Bytes whose enable is low keep their old value, which allows byte and halfword stores.
- R7: A write strobe on the power-setting input loads bank i's state from bits [2i+1:2i] (00 active, 01 retention, 10 or 11 off) from the next cycle on. The state is visible on the power state output, where off is reported as 10. Without a strobe the state holds.
- R8: In interleaved mode any setting other than active is ignored, and every bank stays active.
- R9: An access to a bank in retention or off gives an error response with read data zero, and a write to such a bank leaves its contents unchanged.
- R10: A bank taken from active to retention and back to active still holds the data it held before.
- R11: An access whose byte address is not a multiple of 4, or whose word index is at or beyond NUM_BANKS*BANK_WORDS, gives an error response with read data zero and changes no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| gnt_o | output | 1 | Request granted this cycle |
| addr_i | input | 32 | Byte address |
| we_i | input | 1 | 1 for write, 0 for read |
| be_i | input | 4 | Byte enables for writes |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Response valid, one cycle after grant |
| rdata_o | output | 32 | Read data, zero for writes and errors |
| err_o | output | 1 | Error response flag, valid with rvalid_o |
| pwr_cfg_we_i | input | 1 | Power-setting register write strobe |
| pwr_cfg_i | input | 2*NUM_BANKS | Requested power state, 2 bits per bank |
| pwr_state_o | output | 2*NUM_BANKS | Current power state per bank |

## Verification
The bench runs a contiguous and an interleaved copy side by side. It sweeps every word of the small memory while one bank sits in retention, so each access is classified as allowed or rejected. A wrong bank split shows up as errors landing on the wrong slice, or as data aliasing between words. Writes are aimed at a retained bank, and the bank is then restored and read. A design that lets such a write through, or that loses the data in retention, returns changed words. Further cases are partial byte enables, the 11 power encoding, misaligned and out-of-range addresses, and attempts to lower the interleaved copy. A design that honours those attempts reports a non-zero power state and starts returning errors.

// File: rtl/pm_bank_mem_pkg.sv
package pm_bank_mem_pkg;

  typedef enum logic [1:0] {
    PW_ACTIVE = 2'b00,
    PW_RETAIN = 2'b01,
    PW_OFF    = 2'b10
  } pw_state_e;

  // Bank that holds a given word index.
  function automatic int unsigned bank_of(input int unsigned word, input int unsigned nb,
                                          input int unsigned bw, input bit il);
    if (il) return word % nb;
    return word / bw;
  endfunction

  // Location of a word inside its bank.
  function automatic int unsigned offset_of(input int unsigned word, input int unsigned nb,
                                            input int unsigned bw, input bit il);
    if (il) return word / nb;
    return word % bw;
  endfunction

  // Field decode: 00 active, 01 retention, anything else off.
  function automatic pw_state_e decode_pw(input logic [1:0] f);
    case (f)
      2'b00:   return PW_ACTIVE;
      2'b01:   return PW_RETAIN;
      default: return PW_OFF;
    endcase
  endfunction

endpackage

// File: rtl/pm_bank_decoder.sv
module pm_bank_decoder
  import pm_bank_mem_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_WORDS = 64,
  parameter bit INTERLEAVED = 1'b0,
  localparam int BIW = $clog2(NUM_BANKS),
  localparam int OFW = $clog2(BANK_WORDS)
) (
  input  logic [29:0]    word_i,
  input  logic [1:0]     byte_i,
  output logic [BIW-1:0] bank_o,
  output logic [OFW-1:0] off_o,
  output logic           in_range_o
);
  localparam int unsigned TOTAL_WORDS = NUM_BANKS * BANK_WORDS;

  int unsigned word_u;

  always_comb begin
    word_u     = {2'b00, word_i};
    bank_o     = BIW'(bank_of(word_u, NUM_BANKS, BANK_WORDS, INTERLEAVED));
    off_o      = OFW'(offset_of(word_u, NUM_BANKS, BANK_WORDS, INTERLEAVED));
    in_range_o = (byte_i == 2'b00) && (word_u < TOTAL_WORDS);
  end
endmodule

// File: rtl/pm_bank_power.sv
module pm_bank_power
  import pm_bank_mem_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter bit INTERLEAVED = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we_i,
  input  logic [2*NUM_BANKS-1:0] cfg_i,
  output logic [2*NUM_BANKS-1:0] state_o,
  output logic [NUM_BANKS-1:0]   active_o
);
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    pw_state_e st_q;
    pw_state_e asked;

    always_comb begin
      asked = decode_pw(cfg_i[2*i +: 2]);
      if (INTERLEAVED && asked != PW_ACTIVE) asked = PW_ACTIVE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        st_q <= PW_ACTIVE;
      else if (cfg_we_i) st_q <= asked;
    end

    assign state_o[2*i +: 2] = st_q;
    assign active_o[i]       = (st_q == PW_ACTIVE);
  end
endmodule

// File: rtl/pm_sram_bank.sv
module pm_sram_bank #(
  parameter int BANK_WORDS = 64,
  parameter int DW         = 32,
  localparam int OFW = $clog2(BANK_WORDS),
  localparam int BEW = DW / 8
) (
  input  logic           clk,
  input  logic           en_i,
  input  logic           we_i,
  input  logic [BEW-1:0] be_i,
  input  logic [OFW-1:0] off_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o
);
  logic [DW-1:0] mem [BANK_WORDS];

  always_ff @(posedge clk) begin
    if (en_i && we_i) begin
      for (int k = 0; k < BEW; k++) begin
        if (be_i[k]) mem[off_i][8*k +: 8] <= wdata_i[8*k +: 8];
      end
    end
    if (en_i && !we_i) rdata_o <= mem[off_i];
  end
endmodule

// File: rtl/pm_bank_mem.sv
module pm_bank_mem
  import pm_bank_mem_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int BANK_WORDS  = 64,
  parameter bit INTERLEAVED = 1'b0,
  localparam int BIW = $clog2(NUM_BANKS),
  localparam int OFW = $clog2(BANK_WORDS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_i,
  output logic                   gnt_o,
  input  logic [31:0]            addr_i,
  input  logic                   we_i,
  input  logic [3:0]             be_i,
  input  logic [31:0]            wdata_i,
  output logic                   rvalid_o,
  output logic [31:0]            rdata_o,
  output logic                   err_o,
  input  logic                   pwr_cfg_we_i,
  input  logic [2*NUM_BANKS-1:0] pwr_cfg_i,
  output logic [2*NUM_BANKS-1:0] pwr_state_o
);
  logic [BIW-1:0]       dec_bank;
  logic [OFW-1:0]       dec_off;
  logic                 dec_in_range;
  logic [NUM_BANKS-1:0] bank_active;
  logic                 hit_active;
  logic [NUM_BANKS-1:0] bank_en;
  logic [31:0]          bank_rd [NUM_BANKS];

  logic           rvalid_q, err_q, rd_q;
  logic [BIW-1:0] sel_q;

  pm_bank_decoder #(
    .NUM_BANKS(NUM_BANKS), .BANK_WORDS(BANK_WORDS), .INTERLEAVED(INTERLEAVED)
  ) u_dec (
    .word_i(addr_i[31:2]), .byte_i(addr_i[1:0]),
    .bank_o(dec_bank), .off_o(dec_off), .in_range_o(dec_in_range)
  );

  pm_bank_power #(
    .NUM_BANKS(NUM_BANKS), .INTERLEAVED(INTERLEAVED)
  ) u_pwr (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(pwr_cfg_we_i), .cfg_i(pwr_cfg_i),
    .state_o(pwr_state_o), .active_o(bank_active)
  );

  assign gnt_o      = req_i;
  assign hit_active = dec_in_range && bank_active[dec_bank];

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign bank_en[i] = req_i && hit_active && (dec_bank == BIW'(i));

    pm_sram_bank #(.BANK_WORDS(BANK_WORDS), .DW(32)) u_bank (
      .clk(clk), .en_i(bank_en[i]), .we_i(we_i), .be_i(be_i),
      .off_i(dec_off), .wdata_i(wdata_i), .rdata_o(bank_rd[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
      rd_q     <= 1'b0;
      sel_q    <= '0;
    end else begin
      rvalid_q <= req_i;
      err_q    <= req_i && !hit_active;
      rd_q     <= req_i && !we_i && hit_active;
      sel_q    <= dec_bank;
    end
  end

  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;
  assign rdata_o  = rd_q ? bank_rd[sel_q] : 32'h0;
endmodule

// File: rtl/pm_bank_mem_chk.sv
module pm_bank_mem_chk #(
  parameter int NUM_BANKS   = 4,
  parameter int BANK_WORDS  = 64,
  parameter bit INTERLEAVED = 1'b0,
  localparam int BIW = $clog2(NUM_BANKS),
  localparam int OFW = $clog2(BANK_WORDS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_i,
  input logic [31:0]            addr_i,
  input logic                   pwr_cfg_we_i,
  input logic                   rvalid_o,
  input logic                   err_o,
  input logic [31:0]            rdata_o,
  input logic [2*NUM_BANKS-1:0] pwr_state_o,
  input logic [BIW-1:0]         dec_bank,
  input logic                   dec_in_range
);
  assert_req_gives_rvalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> rvalid_o);

  assert_idle_no_rvalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !rvalid_o);

  assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (rdata_o == 32'h0));

  assert_inactive_bank_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && dec_in_range && (pwr_state_o[2*dec_bank +: 2] != 2'b00)) |=> err_o);

  assert_bad_addr_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !dec_in_range) |=> err_o);

  assert_state_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_cfg_we_i |=> $stable(pwr_state_o));

  if (INTERLEAVED) begin : g_il
    assert_all_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_state_o == '0);
    assert_low_bits_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && dec_in_range) |-> (dec_bank == addr_i[2 +: BIW]));
  end else begin : g_ct
    assert_high_bits_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && dec_in_range) |-> (dec_bank == addr_i[2+OFW +: BIW]));
  end
endmodule

bind pm_bank_mem pm_bank_mem_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_WORDS(BANK_WORDS), .INTERLEAVED(INTERLEAVED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
  .pwr_cfg_we_i(pwr_cfg_we_i), .rvalid_o(rvalid_o), .err_o(err_o),
  .rdata_o(rdata_o), .pwr_state_o(pwr_state_o),
  .dec_bank(dec_bank), .dec_in_range(dec_in_range)
);

// File: tb/test_pm_bank_mem.sv
`timescale 1ns/1ps
module test_pm_bank_mem;
  localparam int NB    = 4;
  localparam int BW    = 64;
  localparam int TOTAL = NB * BW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [3:0] be = '0;
  logic cfg_we = 1'b0;
  logic [2*NB-1:0] cfg = '0;

  logic gnt_c, rvalid_c, err_c, gnt_i, rvalid_i, err_i;
  logic [31:0] rdata_c, rdata_i;
  logic [2*NB-1:0] st_out_c, st_out_i;

  int checks = 0, failures = 0;
  logic [31:0] exp_c [TOTAL];
  logic [31:0] exp_i [TOTAL];
  logic [1:0]  st_c [NB];

  always #2.5 clk = ~clk;

  pm_bank_mem #(.NUM_BANKS(NB), .BANK_WORDS(BW), .INTERLEAVED(1'b0)) i_pm_bank_mem (
    .clk(clk), .rst_n(rst_n), .req_i(req), .gnt_o(gnt_c), .addr_i(addr), .we_i(we),
    .be_i(be), .wdata_i(wdata), .rvalid_o(rvalid_c), .rdata_o(rdata_c), .err_o(err_c),
    .pwr_cfg_we_i(cfg_we), .pwr_cfg_i(cfg), .pwr_state_o(st_out_c));

  pm_bank_mem #(.NUM_BANKS(NB), .BANK_WORDS(BW), .INTERLEAVED(1'b1)) i_pm_bank_mem_il (
    .clk(clk), .rst_n(rst_n), .req_i(req), .gnt_o(gnt_i), .addr_i(addr), .we_i(we),
    .be_i(be), .wdata_i(wdata), .rvalid_o(rvalid_i), .rdata_o(rdata_i), .err_o(err_i),
    .pwr_cfg_we_i(cfg_we), .pwr_cfg_i(cfg), .pwr_state_o(st_out_i));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] b);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (b[k]) r[8*k +: 8] = nw[8*k +: 8];
    return r;
  endfunction

  function automatic logic [31:0] pat(input int w, input int salt);
    logic [7:0] x = 8'(w);
    return {x ^ 8'h5A, ~x, x + 8'(salt), 8'hC3 ^ 8'(salt)};
  endfunction

  // One access on both copies; expected results from the bench's own model.
  task automatic acc(input logic w, input logic [31:0] a, input logic [3:0] b,
                     input logic [31:0] d, input string tag);
    int wi;
    bit inr, ec;
    logic [31:0] ed_c, ed_i;
    wi  = int'(a[31:2]);
    inr = (a[1:0] == 2'b00) && (a[31:2] < TOTAL);
    ec  = !inr || (st_c[wi / BW] != 2'b00);   // contiguous: bank = word / BW (R3)
    ed_c = (!w && !ec) ? exp_c[wi] : 32'h0;
    ed_i = (!w && inr) ? exp_i[wi] : 32'h0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    #1;
    chk(gnt_c && gnt_i, {tag, " R2 grant"}, {31'h0, gnt_c & gnt_i}, 32'h1);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk(rvalid_c && rvalid_i, {tag, " R5 rvalid"}, {31'h0, rvalid_c & rvalid_i}, 32'h1);
    chk(err_c == ec, {tag, " err contiguous"}, {31'h0, err_c}, {31'h0, ec});
    chk(err_i == !inr, {tag, " err interleaved"}, {31'h0, err_i}, {31'h0, !inr});
    chk(rdata_c == ed_c, {tag, " rdata contiguous"}, rdata_c, ed_c);
    chk(rdata_i == ed_i, {tag, " rdata interleaved"}, rdata_i, ed_i);
    if (w && !ec) exp_c[wi] = merge(exp_c[wi], d, b);
    if (w && inr) exp_i[wi] = merge(exp_i[wi], d, b);
  endtask

  task automatic set_pwr(input logic [2*NB-1:0] v);
    logic [2*NB-1:0] shown;
    @(negedge clk);
    cfg_we = 1'b1; cfg = v;
    @(negedge clk);
    cfg_we = 1'b0;
    for (int i = 0; i < NB; i++) begin
      st_c[i] = v[2*i +: 2];
      shown[2*i +: 2] = (v[2*i +: 2] == 2'b11) ? 2'b10 : v[2*i +: 2];
    end
    chk(st_out_c == shown, "R7 power state contiguous", 32'(st_out_c), 32'(shown));
    chk(st_out_i == '0, "R8 interleaved stays active", 32'(st_out_i), 32'h0);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) st_c[i] = 2'b00;
    #1;
    repeat (3) @(negedge clk);
    chk(st_out_c == '0 && st_out_i == '0, "R1 reset power state", 32'(st_out_c), 32'h0);
    chk(!rvalid_c && !rvalid_i, "R1 reset rvalid", {31'h0, rvalid_c}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rvalid_c && !rvalid_i, "R5 no request no rvalid", {31'h0, rvalid_c}, 32'h0);

    // R3 R4: full write and read sweep.
    for (int w = 0; w < TOTAL; w++) acc(1'b1, 32'(w*4), 4'hF, pat(w, 1), "R4 sweep write");
    for (int w = 0; w < TOTAL; w++) acc(1'b0, 32'(w*4), 4'h0, 32'h0, "R4 sweep read");

    // R6: partial byte enables.
    acc(1'b1, 32'h0000_0010, 4'b0001, 32'hDEAD_BEEF, "R6 byte0");
    acc(1'b1, 32'h0000_0024, 4'b0110, 32'h1234_5678, "R6 mid half");
    acc(1'b1, 32'h0000_0108, 4'b1000, 32'hAB00_0000, "R6 byte3");
    acc(1'b1, 32'h0000_03F0, 4'b1100, 32'h9876_0000, "R6 upper half");
    acc(1'b1, 32'h0000_0200, 4'b0000, 32'hFFFF_FFFF, "R6 no bytes");
    foreach (exp_c[w]) if (w == 4 || w == 9 || w == 66 || w == 252 || w == 128)
      acc(1'b0, 32'(w*4), 4'h0, 32'h0, "R6 readback");

    // R3 R9: bank 2 in retention; sweep shows which slice is rejected.
    set_pwr(8'b00_01_00_00);
    for (int w = 0; w < TOTAL; w++) acc(1'b0, 32'(w*4), 4'h0, 32'h0, "R3 R9 retention sweep");
    for (int w = 128; w < 132; w++) acc(1'b1, 32'(w*4), 4'hF, 32'hBAD0_0000 | 32'(w), "R9 write retained");
    acc(1'b1, 32'h0000_0028, 4'hF, 32'h0F0F_0F0F, "R9 write active bank");

    // R10: back to active, retained contents intact.
    set_pwr(8'b00_00_00_00);
    for (int w = 0; w < TOTAL; w++) acc(1'b0, 32'(w*4), 4'h0, 32'h0, "R10 restore sweep");

    // R7 R9: bank 1 off (10), bank 3 off via 11.
    set_pwr(8'b11_00_10_00);
    for (int w = 60; w < 70; w++) acc(1'b0, 32'(w*4), 4'h0, 32'h0, "R9 off bank read");
    for (int w = 190; w < 200; w++) acc(1'b1, 32'(w*4), 4'hF, pat(w, 7), "R9 off bank write");
    set_pwr(8'b00_00_00_00);
    for (int w = 64; w < 128; w++) acc(1'b1, 32'(w*4), 4'hF, pat(w, 3), "R7 rewrite bank1");
    for (int w = 192; w < 256; w++) acc(1'b1, 32'(w*4), 4'hF, pat(w, 5), "R7 rewrite bank3");
    for (int w = 0; w < TOTAL; w++) acc(1'b0, 32'(w*4), 4'h0, 32'h0, "R7 after off sweep");

    // R11: misaligned and out-of-range.
    acc(1'b0, 32'h0000_0005, 4'h0, 32'h0, "R11 misaligned read");
    acc(1'b1, 32'h0000_0012, 4'hF, 32'h1111_1111, "R11 misaligned write");
    acc(1'b0, 32'h0000_0400, 4'h0, 32'h0, "R11 past end read");
    acc(1'b1, 32'hFFFF_FFFC, 4'hF, 32'h2222_2222, "R11 past end write");
    acc(1'b0, 32'h0000_0010, 4'h0, 32'h0, "R11 word untouched");
    acc(1'b0, 32'h0000_0000, 4'h0, 32'h0, "R11 word0 untouched");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule